// File: doc/BRIEF.md
# CCD Timing Mode and Standby Output Gate

This block sits between the raw pulse generator of a CCD camera timing chip and its output pins. It receives every raw pulse (pixel clock, master clock, charge readout pulses, vertical and horizontal register clocks, reset gate, discharge pulse, the sample-and-hold family, delay-line clocks, clamps, blanking, line identification, write enable and burst gate). It applies the operating mode chosen by three static selects, which are processing style, monochrome and test. It also applies the standby state requested over two control inputs. Every gated output leaves through one register stage clocked by the system clock, so mode and standby changes take effect on a clock edge. Frozen outputs always hold a clean registered value.

Four select combinations are legal. The rest raise an error flag and are handled as a full standby. When digital processing is selected, a flag tells the pad logic that two of the clamp pins serve as standby control inputs. Those two inputs reach this block as a run input and a keep-pixel-clock input.

Top module: `ccd_mode_gate`

## Requirements
- R1: While reset is asserted, every output, including both flags, is low.
- R2: In analog color mode (processing select 0, monochrome 0, test 0), each gated output equals its raw input one clock later.
- R3: In first digital color mode (1/0/0, not in standby), both color-separation outputs are held high, both switching sample outputs are held low, delay-line output bit 0 is held high and bit 1 is held low. All other outputs pass through one clock later.
- R4: In second digital color mode (1/0/1, not in standby), the color-separation and delay-line outputs are held as in R3, while the switching sample outputs pass through.
- R5: In analog monochrome mode (0/1/0), the color-separation and delay-line outputs are held as in R3, and burst and line ID are held low. Switching output bit 0 carries the raw precharge sample pulse and bit 1 carries the raw data sample pulse.
- R6: The clamp-pin direction flag equals the processing select one clock later.
- R7: Standby is requested when the processing select is 1 and the run input is 0. With keep-pixel-clock at 0, the pixel clock and every readout, vertical, horizontal, reset-gate, discharge, sample-and-hold, color-separation, switching and delay-line output goes low one clock later.
- R8: In standby with keep-pixel-clock at 1, the pixel clock output keeps following its raw input, while the other outputs listed in R7 stay low.
- R9: With the run input at 1, or with the processing select at 0, the standby inputs have no effect on any output.
- R10: During standby, the master clock, clamp, blanking, line ID, write-enable and burst outputs keep the value they had in the cycle before standby began.
- R11: The select combinations 0/0/1, 0/1/1, 1/1/0 and 1/1/1 set the error flag one clock later. They gate all outputs as in R7 and R10, with the pixel clock low whatever the keep input is.
- R12: One clock after the standby request is withdrawn, all outputs again follow the mode rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proc_dig_i | input | 1 | Processing select: 0 analog, 1 digital |
| mono_i | input | 1 | Monochrome select |
| test_i | input | 1 | Test select |
| stby_run_i | input | 1 | Standby control: 1 normal operation |
| stby_keep_pix_i | input | 1 | Standby variant: 1 keeps pixel clock running |
| raw_pix_i | input | 1 | Raw pixel clock |
| raw_mclk_i | input | 1 | Raw master clock |
| raw_read_i | input | N_READ | Raw charge readout pulses |
| raw_vclk_i | input | N_VCLK | Raw vertical register clocks |
| raw_disch_i | input | 1 | Raw discharge pulse |
| raw_hclk_i | input | N_HCLK | Raw horizontal register clocks |
| raw_rgate_i | input | 1 | Raw reset gate pulse |
| raw_shp_i | input | 1 | Raw precharge sample pulse |
| raw_shd_i | input | 1 | Raw data sample pulse |
| raw_csep_i | input | 2 | Raw color-separation sample pulses |
| raw_swsh_i | input | 2 | Raw switching sample pulses |
| raw_dl_i | input | 2 | Raw delay-line clocks |
| raw_clamp_i | input | N_CLAMP | Raw clamp pulses |
| raw_blank_i | input | 1 | Raw blanking pulse |
| raw_lid_i | input | 1 | Raw line ID |
| raw_wen_i | input | 1 | Raw write enable |
| raw_burst_i | input | 1 | Raw burst gate |
| pix_o | output | 1 | Gated pixel clock |
| mclk_o | output | 1 | Gated master clock |
| read_o | output | N_READ | Gated readout pulses |
| vclk_o | output | N_VCLK | Gated vertical clocks |
| disch_o | output | 1 | Gated discharge pulse |
| hclk_o | output | N_HCLK | Gated horizontal clocks |
| rgate_o | output | 1 | Gated reset gate |
| shp_o | output | 1 | Gated precharge sample pulse |
| shd_o | output | 1 | Gated data sample pulse |
| csep_o | output | 2 | Gated color-separation pulses |
| swsh_o | output | 2 | Gated switching sample pulses |
| dl_o | output | 2 | Gated delay-line clocks |
| clamp_o | output | N_CLAMP | Gated clamp pulses |
| blank_o | output | 1 | Gated blanking |
| lid_o | output | 1 | Gated line ID |
| wen_o | output | 1 | Gated write enable |
| burst_o | output | 1 | Gated burst gate |
| clamp_in_mode_o | output | 1 | Clamp pins 2 and 3 act as standby inputs |
| mode_err_o | output | 1 | Illegal select combination |

## Verification
The raw pulse bundle is random on every cycle, so a held output, a passed output and a repurposed output show up as different values. Each legal mode is run with the standby inputs in several settings, which tells steering faults apart from standby faults. Standby is entered in both variants and then left again, and the frozen group is compared against the value from before entry. This separates holding from forcing low and shows whether the pixel clock is treated on its own. All four illegal combinations are driven to confirm the error flag and the full-halt behaviour.

// File: rtl/ccd_gate_pkg.sv
package ccd_gate_pkg;

   localparam int PAIR_W = 2;

   typedef enum logic [2:0] {
      MD_ANA_COLOR  = 3'd0,
      MD_DIG_COLOR1 = 3'd1,
      MD_DIG_COLOR2 = 3'd2,
      MD_ANA_MONO   = 3'd3,
      MD_BAD        = 3'd4
   } op_mode_e;

   function automatic op_mode_e decode_mode(input logic dig, input logic mono, input logic test);
      op_mode_e m;
      case ({dig, mono, test})
         3'b000:  m = MD_ANA_COLOR;
         3'b100:  m = MD_DIG_COLOR1;
         3'b101:  m = MD_DIG_COLOR2;
         3'b010:  m = MD_ANA_MONO;
         default: m = MD_BAD;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ccd_mode_decode.sv
module ccd_mode_decode
   import ccd_gate_pkg::*;
(
   input  logic     dig,
   input  logic     mono,
   input  logic     test,
   output op_mode_e mode,
   output logic     illegal
);
   always_comb begin
      mode    = decode_mode(dig, mono, test);
      illegal = (mode == MD_BAD);
   end
endmodule

// File: rtl/ccd_stby_ctl.sv
module ccd_stby_ctl (
   input  logic illegal,
   input  logic dig,
   input  logic run,
   input  logic keep_pix,
   output logic halt_all,
   output logic halt_pix
);
   logic stby_req;

   always_comb begin
      // the two clamp pins only act as standby inputs with digital processing
      stby_req = dig && !run;
      halt_all = illegal || stby_req;
      halt_pix = illegal || (stby_req && !keep_pix);
   end
endmodule

// File: rtl/ccd_color_steer.sv
module ccd_color_steer
   import ccd_gate_pkg::*;
(
   input  op_mode_e          mode,
   input  logic [PAIR_W-1:0] csep_raw,
   input  logic [PAIR_W-1:0] swsh_raw,
   input  logic [PAIR_W-1:0] dl_raw,
   input  logic              shp_raw,
   input  logic              shd_raw,
   input  logic              burst_raw,
   input  logic              lid_raw,
   output logic [PAIR_W-1:0] csep_s,
   output logic [PAIR_W-1:0] swsh_s,
   output logic [PAIR_W-1:0] dl_s,
   output logic              burst_s,
   output logic              lid_s
);
   localparam logic [PAIR_W-1:0] CSEP_IDLE = '1;
   localparam logic [PAIR_W-1:0] DL_IDLE   = PAIR_W'(1);

   always_comb begin
      csep_s  = csep_raw;
      swsh_s  = swsh_raw;
      dl_s    = dl_raw;
      burst_s = burst_raw;
      lid_s   = lid_raw;
      unique case (mode)
         MD_ANA_COLOR: ;
         MD_DIG_COLOR1: begin
            csep_s = CSEP_IDLE;
            swsh_s = '0;
            dl_s   = DL_IDLE;
         end
         MD_DIG_COLOR2: begin
            csep_s = CSEP_IDLE;
            dl_s   = DL_IDLE;
         end
         MD_ANA_MONO: begin
            csep_s  = CSEP_IDLE;
            dl_s    = DL_IDLE;
            swsh_s  = {shd_raw, shp_raw};
            burst_s = 1'b0;
            lid_s   = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ccd_gate_reg.sv
module ccd_gate_reg #(
   parameter int W    = 1,
   parameter bit HOLD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         halt,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("ccd_gate_reg: W must be at least 1");
   end

   if (HOLD) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (!halt) q <= d;
      end
   end else begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= halt ? '0 : d;
      end
   end
endmodule

// File: rtl/ccd_mode_gate.sv
module ccd_mode_gate
   import ccd_gate_pkg::*;
#(
   parameter int N_READ  = 2,
   parameter int N_VCLK  = 4,
   parameter int N_HCLK  = 2,
   parameter int N_CLAMP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               proc_dig_i,
   input  logic               mono_i,
   input  logic               test_i,
   input  logic               stby_run_i,
   input  logic               stby_keep_pix_i,
   input  logic               raw_pix_i,
   input  logic               raw_mclk_i,
   input  logic [N_READ-1:0]  raw_read_i,
   input  logic [N_VCLK-1:0]  raw_vclk_i,
   input  logic               raw_disch_i,
   input  logic [N_HCLK-1:0]  raw_hclk_i,
   input  logic               raw_rgate_i,
   input  logic               raw_shp_i,
   input  logic               raw_shd_i,
   input  logic [1:0]         raw_csep_i,
   input  logic [1:0]         raw_swsh_i,
   input  logic [1:0]         raw_dl_i,
   input  logic [N_CLAMP-1:0] raw_clamp_i,
   input  logic               raw_blank_i,
   input  logic               raw_lid_i,
   input  logic               raw_wen_i,
   input  logic               raw_burst_i,
   output logic               pix_o,
   output logic               mclk_o,
   output logic [N_READ-1:0]  read_o,
   output logic [N_VCLK-1:0]  vclk_o,
   output logic               disch_o,
   output logic [N_HCLK-1:0]  hclk_o,
   output logic               rgate_o,
   output logic               shp_o,
   output logic               shd_o,
   output logic [1:0]         csep_o,
   output logic [1:0]         swsh_o,
   output logic [1:0]         dl_o,
   output logic [N_CLAMP-1:0] clamp_o,
   output logic               blank_o,
   output logic               lid_o,
   output logic               wen_o,
   output logic               burst_o,
   output logic               clamp_in_mode_o,
   output logic               mode_err_o
);
   localparam int LOW_W    = N_READ + N_VCLK + 1 + N_HCLK + 1 + 1 + 1 + 3*PAIR_W;
   localparam int FREEZE_W = 1 + N_CLAMP + 4;

   if (N_READ < 1 || N_VCLK < 1 || N_HCLK < 1) begin : g_bad_drive
      $error("ccd_mode_gate: drive pulse widths must be at least 1");
   end
   if (N_CLAMP < 3) begin : g_bad_clamp
      $error("ccd_mode_gate: at least three clamp pulses are required");
   end

   op_mode_e          mode;
   logic              illegal;
   logic              halt_all;
   logic              halt_pix;
   logic [PAIR_W-1:0] csep_s, swsh_s, dl_s;
   logic              burst_s, lid_s;
   logic [LOW_W-1:0]    low_d, low_q;
   logic [FREEZE_W-1:0] frz_d, frz_q;

   ccd_mode_decode u_dec (
      .dig     (proc_dig_i),
      .mono    (mono_i),
      .test    (test_i),
      .mode    (mode),
      .illegal (illegal)
   );

   ccd_stby_ctl u_stby (
      .illegal  (illegal),
      .dig      (proc_dig_i),
      .run      (stby_run_i),
      .keep_pix (stby_keep_pix_i),
      .halt_all (halt_all),
      .halt_pix (halt_pix)
   );

   ccd_color_steer u_steer (
      .mode      (mode),
      .csep_raw  (raw_csep_i),
      .swsh_raw  (raw_swsh_i),
      .dl_raw    (raw_dl_i),
      .shp_raw   (raw_shp_i),
      .shd_raw   (raw_shd_i),
      .burst_raw (raw_burst_i),
      .lid_raw   (raw_lid_i),
      .csep_s    (csep_s),
      .swsh_s    (swsh_s),
      .dl_s      (dl_s),
      .burst_s   (burst_s),
      .lid_s     (lid_s)
   );

   assign low_d = {raw_read_i, raw_vclk_i, raw_disch_i, raw_hclk_i, raw_rgate_i,
                   raw_shp_i, raw_shd_i, csep_s, swsh_s, dl_s};
   assign frz_d = {raw_mclk_i, raw_clamp_i, raw_blank_i, lid_s, raw_wen_i, burst_s};

   ccd_gate_reg #(.W(LOW_W), .HOLD(1'b0)) u_low (
      .clk (clk), .rst_n (rst_n), .halt (halt_all), .d (low_d), .q (low_q)
   );

   ccd_gate_reg #(.W(FREEZE_W), .HOLD(1'b1)) u_frz (
      .clk (clk), .rst_n (rst_n), .halt (halt_all), .d (frz_d), .q (frz_q)
   );

   ccd_gate_reg #(.W(1), .HOLD(1'b0)) u_pix (
      .clk (clk), .rst_n (rst_n), .halt (halt_pix), .d (raw_pix_i), .q (pix_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clamp_in_mode_o <= 1'b0;
         mode_err_o      <= 1'b0;
      end else begin
         clamp_in_mode_o <= proc_dig_i;
         mode_err_o      <= illegal;
      end
   end

   assign {read_o, vclk_o, disch_o, hclk_o, rgate_o, shp_o, shd_o, csep_o, swsh_o, dl_o} = low_q;
   assign {mclk_o, clamp_o, blank_o, lid_o, wen_o, burst_o} = frz_q;

endmodule

// File: rtl/ccd_mode_gate_chk.sv
module ccd_mode_gate_chk #(
   parameter int N_READ  = 2,
   parameter int N_VCLK  = 4,
   parameter int N_HCLK  = 2,
   parameter int N_CLAMP = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               proc_dig_i,
   input logic               mono_i,
   input logic               test_i,
   input logic               stby_run_i,
   input logic               stby_keep_pix_i,
   input logic               raw_pix_i,
   input logic               raw_shp_i,
   input logic               raw_shd_i,
   input logic               pix_o,
   input logic               mclk_o,
   input logic [N_READ-1:0]  read_o,
   input logic [N_VCLK-1:0]  vclk_o,
   input logic               disch_o,
   input logic [N_HCLK-1:0]  hclk_o,
   input logic               rgate_o,
   input logic [1:0]         csep_o,
   input logic [1:0]         swsh_o,
   input logic [1:0]         dl_o,
   input logic [N_CLAMP-1:0] clamp_o,
   input logic               blank_o,
   input logic               lid_o,
   input logic               wen_o,
   input logic               burst_o,
   input logic               clamp_in_mode_o,
   input logic               mode_err_o
);
   // R3
   dig1_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_dig_i && !mono_i && !test_i && stby_run_i)
      |=> (csep_o == 2'b11 && swsh_o == 2'b00 && dl_o == 2'b01));

   // R5
   mono_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_dig_i && mono_i && !test_i)
      |=> (!burst_o && !lid_o && swsh_o == {$past(raw_shd_i), $past(raw_shp_i)}));

   // R6
   pin_flag_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proc_dig_i |=> clamp_in_mode_o);

   // R6
   pin_flag_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_dig_i |=> !clamp_in_mode_o);

   // R7
   stby_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_dig_i && !stby_run_i && !stby_keep_pix_i)
      |=> (!pix_o && read_o == '0 && vclk_o == '0 && hclk_o == '0 && !rgate_o && !disch_o));

   // R8
   keep_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_dig_i && !mono_i && !stby_run_i && stby_keep_pix_i)
      |=> (pix_o == $past(raw_pix_i) && vclk_o == '0));

   // R10
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_dig_i && !stby_run_i)
      |=> ($stable(mclk_o) && $stable(clamp_o) && $stable(blank_o) &&
           $stable(lid_o) && $stable(wen_o) && $stable(burst_o)));

   // R11
   bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!proc_dig_i && test_i) || (proc_dig_i && mono_i)) |=> (mode_err_o && !pix_o));

endmodule

bind ccd_mode_gate ccd_mode_gate_chk #(
   .N_READ(N_READ), .N_VCLK(N_VCLK), .N_HCLK(N_HCLK), .N_CLAMP(N_CLAMP)
) u_chk (.*);

// File: tb/ccd_mode_gate_test.sv
module ccd_mode_gate_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic dig = 1'b0, mono = 1'b0, test = 1'b0, run = 1'b1, keep = 1'b0;
   logic [27:0] raw = '0;

   logic r_pix, r_mclk, r_disch, r_rg, r_shp, r_shd, r_blank, r_lid, r_wen, r_burst;
   logic [1:0] r_read, r_hclk, r_csep, r_swsh, r_dl;
   logic [3:0] r_vclk, r_clamp;
   assign {r_pix, r_mclk, r_read, r_vclk, r_disch, r_hclk, r_rg, r_shp, r_shd,
           r_csep, r_swsh, r_dl, r_clamp, r_blank, r_lid, r_wen, r_burst} = raw;

   logic o_pix, o_mclk, o_disch, o_rg, o_shp, o_shd, o_blank, o_lid, o_wen, o_burst, o_cin, o_err;
   logic [1:0] o_read, o_hclk, o_csep, o_swsh, o_dl;
   logic [3:0] o_vclk, o_clamp;
   logic [29:0] out_vec;
   assign out_vec = {o_pix, o_mclk, o_read, o_vclk, o_disch, o_hclk, o_rg, o_shp, o_shd,
                     o_csep, o_swsh, o_dl, o_clamp, o_blank, o_lid, o_wen, o_burst, o_cin, o_err};

   ccd_mode_gate uut (
      .clk(clk), .rst_n(rst_n), .proc_dig_i(dig), .mono_i(mono), .test_i(test),
      .stby_run_i(run), .stby_keep_pix_i(keep),
      .raw_pix_i(r_pix), .raw_mclk_i(r_mclk), .raw_read_i(r_read), .raw_vclk_i(r_vclk),
      .raw_disch_i(r_disch), .raw_hclk_i(r_hclk), .raw_rgate_i(r_rg), .raw_shp_i(r_shp),
      .raw_shd_i(r_shd), .raw_csep_i(r_csep), .raw_swsh_i(r_swsh), .raw_dl_i(r_dl),
      .raw_clamp_i(r_clamp), .raw_blank_i(r_blank), .raw_lid_i(r_lid), .raw_wen_i(r_wen),
      .raw_burst_i(r_burst),
      .pix_o(o_pix), .mclk_o(o_mclk), .read_o(o_read), .vclk_o(o_vclk), .disch_o(o_disch),
      .hclk_o(o_hclk), .rgate_o(o_rg), .shp_o(o_shp), .shd_o(o_shd), .csep_o(o_csep),
      .swsh_o(o_swsh), .dl_o(o_dl), .clamp_o(o_clamp), .blank_o(o_blank), .lid_o(o_lid),
      .wen_o(o_wen), .burst_o(o_burst), .clamp_in_mode_o(o_cin), .mode_err_o(o_err)
   );

   typedef struct {
      logic [29:0] v;
      string       tag;
   } exp_item_t;

   exp_item_t   sb[$];
   int          checks = 0;
   int          failures = 0;
   logic [27:0] prev = '0;

   // expected outputs from the requirements; prev is the last expected gated bundle
   function automatic logic [29:0] model(input logic g, m, t, r, k, input logic [27:0] x,
                                         inout logic [27:0] last);
      logic [27:0] e;
      logic legal, stby, h_all, h_pix;
      legal = ({g, m, t} == 3'b000) || ({g, m, t} == 3'b100) ||
              ({g, m, t} == 3'b101) || ({g, m, t} == 3'b010);
      stby  = legal && g && !r;
      h_all = !legal || stby;
      h_pix = !legal || (stby && !k);
      e = x;
      if (g || m) begin
         e[13:12] = 2'b11;
         e[9:8]   = 2'b01;
      end
      if (g && !t) e[11:10] = 2'b00;
      if (m) begin
         e[11] = x[14];
         e[10] = x[15];
         e[2]  = 1'b0;
         e[0]  = 1'b0;
      end
      if (h_all) begin
         e[25:8] = '0;
         e[26]   = last[26];
         e[7:0]  = last[7:0];
         e[27]   = h_pix ? 1'b0 : x[27];
      end
      last = e;
      return {e, g, !legal};
   endfunction

   task automatic drive(input logic [2:0] gmt, input logic r, input logic k, input string tag);
      exp_item_t it;
      logic [27:0] nx;
      @(negedge clk);
      nx = 28'($urandom);
      {dig, mono, test} = gmt;
      run  = r;
      keep = k;
      raw  = nx;
      it.v   = model(gmt[2], gmt[1], gmt[0], r, k, nx, prev);
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: one registered result per driven cycle
   initial begin
      exp_item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (out_vec !== it.v) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", it.tag, out_vec, it.v);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: outputs low while in reset, even with active inputs
      dig = 1'b1; raw = '1;
      repeat (3) @(negedge clk);
      checks++;
      if (out_vec !== '0) begin
         failures++;
         $display("FAIL R1 actual=%h expected=%h", out_vec, 30'h0);
      end
      dig = 1'b0; raw = '0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 6; i++) drive(3'b000, 1'b1, 1'b0, "R2 analog color");
      for (int i = 0; i < 5; i++) drive(3'b100, 1'b1, i[0], "R3 digital color 1");
      for (int i = 0; i < 5; i++) drive(3'b101, 1'b1, i[0], "R4 digital color 2");
      for (int i = 0; i < 5; i++) drive(3'b010, 1'b1, 1'b0, "R5 analog mono");
      for (int i = 0; i < 3; i++) drive(3'b000, 1'b0, i[0], "R9 analog ignores standby");
      for (int i = 0; i < 3; i++) drive(3'b010, 1'b0, 1'b1, "R9 mono ignores standby");
      drive(3'b100, 1'b1, 1'b0, "R6 flag high");
      for (int i = 0; i < 5; i++) drive(3'b100, 1'b0, 1'b0, "R7 R10 full standby");
      for (int i = 0; i < 3; i++) drive(3'b100, 1'b1, 1'b0, "R12 exit standby");
      for (int i = 0; i < 5; i++) drive(3'b101, 1'b0, 1'b1, "R8 R10 keep pixel clock");
      for (int i = 0; i < 3; i++) drive(3'b101, 1'b1, 1'b1, "R12 exit keep standby");
      drive(3'b000, 1'b1, 1'b0, "R6 flag low");
      drive(3'b001, 1'b1, 1'b1, "R11 illegal 001");
      drive(3'b001, 1'b1, 1'b1, "R11 illegal 001");
      drive(3'b011, 1'b1, 1'b0, "R11 illegal 011");
      drive(3'b110, 1'b1, 1'b1, "R11 illegal 110");
      drive(3'b111, 1'b0, 1'b1, "R11 illegal 111");
      for (int i = 0; i < 3; i++) drive(3'b000, 1'b1, 1'b0, "R12 back to legal");

      @(negedge clk);
      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule